// File: doc/BRIEF.md
# Slot selector with empty-slot float guard

This block sits between the CPU bus of an MSX-style home computer and its slotted devices. The 64 KB memory space is cut into four 16 KB pages. A primary slot register, written and read through an I/O port, picks one of four slots for each page. A slot that is marked as expanded carries its own sub-slot register at the top memory address, and that register picks one of four sub-slots for each page. From the address, the strobes and these registers, the block drives one-hot slot and sub-slot chip selects. It also drives a dedicated select for a 16 KB flash window that lives in slot 3, sub-slot 1, page 1.

A configuration input says which slot and sub-slot positions have a device fitted. When a memory read lands on an empty position, the block drives 0xFF onto the data bus itself. Without this, the bus would hold its last value, and software that probes for RAM by writing a byte and reading it back would find a device that is not there.

The slot registers are level-sensitive latches that are open while the write strobe is high. A read that follows a write therefore returns the new value at once, with no bus clock edge in between. The clock input is used only to synchronise the release of reset.

Top module: `slot_selector`

## Requirements
- R1: An I/O write whose low 8 address bits equal 0xA8 loads the primary slot register. An I/O read of that port returns the register on data_out with data_oe high.
- R2: A register write is visible on readback as soon as the write strobe falls, with no clock edge needed between the write and the read.
- R3: The page is addr[15:14]. The slot chosen for page p is primary register bits [2p+1:2p].
- R4: When the slot chosen for page 3 is expanded, a memory write to 0xFFFF stores into that slot's sub-slot register. A memory read of 0xFFFF returns the bitwise complement of that register with data_oe high. No chip select is active during either access.
- R5: On an expanded slot, the sub-slot for page p is bits [2p+1:2p] of that slot's sub-slot register, and sub_cs is one-hot. On a slot that is not expanded, sub_cs is zero and the position counts as sub-slot 0.
- R6: A memory read of a position whose dev_present bit (index slot*4+sub) is 0 returns 0xFF with data_oe high and no chip select. A write to such a position leaves no trace, so a read-back probe still sees 0xFF.
- R7: A memory access to a populated position raises the one-hot slot_cs bit for its slot, and data_oe stays low.
- R8: flash_cs is high only for a memory access to page 1 when that page maps to slot 3, sub-slot 1 of an expanded slot 3 that is populated.
- R9: Reset clears the primary register and every sub-slot register to 0.
- R10: Without mreq there are no chip selects. data_oe is high only during a read of the primary port, a read of a sub-slot register or a read of an empty position. At all other times data_out is 0.
- R11: I/O writes to any port other than 0xA8 leave the primary register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, used for reset synchronisation |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| data_in | input | 8 | CPU write data |
| mreq | input | 1 | Memory request |
| iorq | input | 1 | I/O request |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (opens the register latches) |
| slot_expanded | input | 4 | Per slot: 1 when the slot has sub-slots |
| dev_present | input | 16 | Per position slot*4+sub: 1 when a device is fitted |
| data_out | output | 8 | Data the block drives onto the bus |
| data_oe | output | 1 | Bus drive enable for data_out |
| slot_cs | output | 4 | One-hot primary slot select |
| sub_cs | output | 4 | One-hot sub-slot select |
| flash_cs | output | 1 | Flash window select |

## Verification
A wrong value held in the primary or a sub-slot register shows up on the very next memory access as the wrong chip select. It can also show up as a 0xFF drive where a device should answer, or as silence where 0xFF was due. The vectors therefore read the registers back through their ports and then walk the pages that depend on them. A register that is captured one step late shows up in a read issued right after the write strobe falls, before any clock edge. That read must already return the new byte.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;
    localparam int FIELD_W   = 2;
    localparam int NUM_SLOTS = 1 << FIELD_W;
    localparam int NUM_POS   = NUM_SLOTS * NUM_SLOTS;

    typedef logic [FIELD_W-1:0] idx_t;

    typedef struct packed {
        idx_t page;
        idx_t slot;
        idx_t sub;
        logic expanded;
        logic present;
        logic subreg_hit;
    } route_t;

    function automatic logic [NUM_SLOTS-1:0] one_hot(input idx_t i);
        logic [NUM_SLOTS-1:0] v;
        v    = '0;
        v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/slot_regfile.sv
module slot_regfile
    import slot_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                             rst_n,
    input  logic                             pri_we,
    input  logic [NUM_SLOTS-1:0]             sub_we,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                pri_q,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] sub_q
);
    // Level-sensitive capture: follows wdata while the strobe is open.
    always_latch begin
        if (!rst_n)      pri_q <= '0;
        else if (pri_we) pri_q <= wdata;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sub
        always_latch begin
            if (!rst_n)         sub_q[s] <= '0;
            else if (sub_we[s]) sub_q[s] <= wdata;
        end
    end
endmodule

// File: rtl/slot_decode.sv
module slot_decode
    import slot_sel_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                IO_PORT_W   = 8,
    parameter logic [IO_PORT_W-1:0] IO_PORT  = 8'hA8,
    parameter logic [ADDR_W-1:0] SUBREG_ADDR = '1,
    parameter int                FLASH_SLOT  = 3,
    parameter int                FLASH_SUB   = 1,
    parameter int                FLASH_PAGE  = 1
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             mreq,
    input  logic                             iorq,
    input  logic                             rd,
    input  logic                             wr,
    input  logic [NUM_SLOTS-1:0]             slot_expanded,
    input  logic [NUM_POS-1:0]               dev_present,
    input  logic [DATA_W-1:0]                pri_q,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] sub_q,
    output logic                             pri_we,
    output logic                             pri_rd,
    output logic [NUM_SLOTS-1:0]             sub_we,
    output logic                             subreg_rd,
    output logic                             float_rd,
    output logic [DATA_W-1:0]                sub_rd_val,
    output logic [NUM_SLOTS-1:0]             slot_cs,
    output logic [NUM_SLOTS-1:0]             sub_cs,
    output logic                             flash_cs
);
    localparam idx_t FL_SLOT = idx_t'(FLASH_SLOT);
    localparam idx_t FL_SUB  = idx_t'(FLASH_SUB);
    localparam idx_t FL_PAGE = idx_t'(FLASH_PAGE);

    route_t route_d;
    logic   port_hit;
    logic   dev_cycle;

    always_comb begin
        route_d.page       = addr[ADDR_W-1 -: FIELD_W];
        route_d.slot       = pri_q[FIELD_W*route_d.page +: FIELD_W];
        route_d.expanded   = slot_expanded[route_d.slot];
        route_d.sub        = route_d.expanded
                           ? sub_q[route_d.slot][FIELD_W*route_d.page +: FIELD_W]
                           : '0;
        route_d.present    = dev_present[{route_d.slot, route_d.sub}];
        route_d.subreg_hit = mreq && route_d.expanded && (addr == SUBREG_ADDR);

        port_hit   = iorq && (addr[IO_PORT_W-1:0] == IO_PORT);
        pri_we     = port_hit && wr;
        pri_rd     = port_hit && rd;

        dev_cycle  = mreq && route_d.present && !route_d.subreg_hit;
        slot_cs    = dev_cycle ? one_hot(route_d.slot) : '0;
        sub_cs     = (dev_cycle && route_d.expanded) ? one_hot(route_d.sub) : '0;
        flash_cs   = dev_cycle && route_d.expanded && (route_d.slot == FL_SLOT)
                  && (route_d.sub == FL_SUB) && (route_d.page == FL_PAGE);

        for (int s = 0; s < NUM_SLOTS; s++) begin
            sub_we[s] = route_d.subreg_hit && wr && (route_d.slot == idx_t'(s));
        end
        subreg_rd  = route_d.subreg_hit && rd;
        sub_rd_val = sub_q[route_d.slot];
        float_rd   = mreq && rd && !route_d.present && !route_d.subreg_hit;
    end
endmodule

// File: rtl/slot_readmux.sv
module slot_readmux #(
    parameter int DATA_W = 8
) (
    input  logic              pri_rd,
    input  logic              subreg_rd,
    input  logic              float_rd,
    input  logic [DATA_W-1:0] pri_q,
    input  logic [DATA_W-1:0] sub_rd_val,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    always_comb begin
        data_out = '0;
        data_oe  = 1'b0;
        if (pri_rd) begin
            data_out = pri_q;
            data_oe  = 1'b1;
        end else if (subreg_rd) begin
            data_out = ~sub_rd_val;
            data_oe  = 1'b1;
        end else if (float_rd) begin
            data_out = '1;
            data_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/slot_selector.sv
module slot_selector
    import slot_sel_pkg::*;
#(
    parameter int                   ADDR_W      = 16,
    parameter int                   DATA_W      = 8,
    parameter int                   IO_PORT_W   = 8,
    parameter logic [IO_PORT_W-1:0] IO_PORT     = 8'hA8,
    parameter logic [ADDR_W-1:0]    SUBREG_ADDR = '1,
    parameter int                   FLASH_SLOT  = 3,
    parameter int                   FLASH_SUB   = 1,
    parameter int                   FLASH_PAGE  = 1,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data_in,
    input  logic                 mreq,
    input  logic                 iorq,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [NUM_SLOTS-1:0] slot_expanded,
    input  logic [NUM_POS-1:0]   dev_present,
    output logic [DATA_W-1:0]    data_out,
    output logic                 data_oe,
    output logic [NUM_SLOTS-1:0] slot_cs,
    output logic [NUM_SLOTS-1:0] sub_cs,
    output logic                 flash_cs
);
    logic                             rst_sync_n;
    logic                             pri_we, pri_rd, subreg_rd, float_rd;
    logic [NUM_SLOTS-1:0]             sub_we;
    logic [DATA_W-1:0]                pri_q, sub_rd_val;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] sub_q;

    slot_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
        .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
    );

    slot_regfile #(.DATA_W(DATA_W)) i_regs (
        .rst_n(rst_sync_n), .pri_we(pri_we), .sub_we(sub_we),
        .wdata(data_in), .pri_q(pri_q), .sub_q(sub_q)
    );

    slot_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_PORT_W(IO_PORT_W), .IO_PORT(IO_PORT),
        .SUBREG_ADDR(SUBREG_ADDR), .FLASH_SLOT(FLASH_SLOT), .FLASH_SUB(FLASH_SUB),
        .FLASH_PAGE(FLASH_PAGE)
    ) i_dec (
        .addr(addr), .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
        .slot_expanded(slot_expanded), .dev_present(dev_present),
        .pri_q(pri_q), .sub_q(sub_q), .pri_we(pri_we), .pri_rd(pri_rd),
        .sub_we(sub_we), .subreg_rd(subreg_rd), .float_rd(float_rd),
        .sub_rd_val(sub_rd_val), .slot_cs(slot_cs), .sub_cs(sub_cs),
        .flash_cs(flash_cs)
    );

    slot_readmux #(.DATA_W(DATA_W)) i_mux (
        .pri_rd(pri_rd), .subreg_rd(subreg_rd), .float_rd(float_rd),
        .pri_q(pri_q), .sub_rd_val(sub_rd_val),
        .data_out(data_out), .data_oe(data_oe)
    );
endmodule

// File: rtl/slot_selector_chk.sv
module slot_selector_chk #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int NSL         = 4,
    parameter int FLASH_SLOT  = 3,
    parameter int FLASH_SUB   = 1,
    parameter int FLASH_PAGE  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              mreq,
    input logic              rd,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic [NSL-1:0]    slot_cs,
    input logic [NSL-1:0]    sub_cs,
    input logic              flash_cs
);
    // R6
    empty_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && mreq && (addr != {ADDR_W{1'b1}})) |-> (data_out == {DATA_W{1'b1}}));

    // R7
    drive_vs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && mreq) |-> (slot_cs == '0 && !flash_cs));

    // R5
    select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_cs) && $onehot0(sub_cs));

    // R8
    flash_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs |-> (slot_cs[FLASH_SLOT] && sub_cs[FLASH_SUB]
                      && (addr[ADDR_W-1 -: 2] == 2'(FLASH_PAGE))));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq |-> (slot_cs == '0 && sub_cs == '0 && !flash_cs));

    // R10
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> rd);
endmodule

bind slot_selector slot_selector_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSL(slot_sel_pkg::NUM_SLOTS),
    .FLASH_SLOT(FLASH_SLOT), .FLASH_SUB(FLASH_SUB), .FLASH_PAGE(FLASH_PAGE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq(mreq), .rd(rd),
    .data_out(data_out), .data_oe(data_oe), .slot_cs(slot_cs),
    .sub_cs(sub_cs), .flash_cs(flash_cs)
);

// File: tb/test_slot_selector.sv
`timescale 1ns/1ps
module test_slot_selector;
    localparam real HALF = 2.5;
    localparam int  NV   = 27;
    // op: 0 I/O write, 1 I/O read, 2 mem write, 3 mem read
    // {op, addr, din, exp dout, exp oe, exp slot_cs, exp sub_cs, exp flash, req}
    localparam logic [47:0] VEC [NV] = '{
        {2'd3, 16'h0000, 8'h00, 8'h00, 1'b0, 4'b0001, 4'b0000, 1'b0, 4'd9},  // R9 reset map
        {2'd3, 16'hC000, 8'h00, 8'h00, 1'b0, 4'b0001, 4'b0000, 1'b0, 4'd9},  // R9
        {2'd0, 16'h00A8, 8'hE4, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd1},  // R1
        {2'd1, 16'h00A8, 8'h00, 8'hE4, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd1},  // R1
        {2'd3, 16'h4000, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6
        {2'd2, 16'h4000, 8'h5A, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6
        {2'd3, 16'h4000, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6 probe
        {2'd3, 16'h8000, 8'h00, 8'h00, 1'b0, 4'b0100, 4'b0000, 1'b0, 4'd3},  // R3
        {2'd3, 16'hC000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b0001, 1'b0, 4'd5},  // R5
        {2'd3, 16'hFFFF, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd4},  // R4
        {2'd2, 16'hFFFF, 8'h64, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd4},  // R4
        {2'd3, 16'hFFFF, 8'h00, 8'h9B, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd4},  // R4
        {2'd3, 16'hC000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b0010, 1'b0, 4'd5},  // R5
        {2'd0, 16'h00A8, 8'hFF, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd1},  // R1
        {2'd3, 16'h4000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b0010, 1'b1, 4'd8},  // R8
        {2'd3, 16'h8000, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6
        {2'd2, 16'h8000, 8'h33, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6
        {2'd3, 16'h8000, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd6},  // R6
        {2'd3, 16'h0000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b0001, 1'b0, 4'd7},  // R7
        {2'd0, 16'h0099, 8'h00, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd11}, // R11
        {2'd1, 16'h00A8, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd11}, // R11
        {2'd1, 16'h0099, 8'h00, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd10}, // R10
        {2'd2, 16'hFFFF, 8'hE4, 8'h00, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd4},  // R4
        {2'd3, 16'hFFFF, 8'h00, 8'h1B, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd4},  // R4
        {2'd3, 16'hC000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b1000, 1'b0, 4'd5},  // R5
        {2'd3, 16'h4000, 8'h00, 8'h00, 1'b0, 4'b1000, 4'b0010, 1'b1, 4'd8},  // R8
        {2'd3, 16'h8000, 8'h00, 8'hFF, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd6}   // R6
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        mreq = 1'b0, iorq = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0]  slot_expanded = 4'b1000;
    logic [15:0] dev_present = 16'hB101;
    logic [7:0]  data_out;
    logic        data_oe, flash_cs;
    logic [3:0]  slot_cs, sub_cs;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(HALF) clk = ~clk;

    slot_selector i_slot_selector (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
        .slot_expanded(slot_expanded), .dev_present(dev_present),
        .data_out(data_out), .data_oe(data_oe), .slot_cs(slot_cs),
        .sub_cs(sub_cs), .flash_cs(flash_cs)
    );

    task automatic check(input int req, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
        addr = a; data_in = d;
        iorq = (op <= 2'd1); mreq = (op >= 2'd2);
        wr = (op == 2'd0 || op == 2'd2); rd = (op == 2'd1 || op == 2'd3);
    endtask

    task automatic release_bus();
        iorq = 1'b0; mreq = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    function automatic logic [17:0] outs();
        return {data_out, data_oe, slot_cs, sub_cs, flash_cs};
    endfunction

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        reset_dut();
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][47:46], VEC[i][45:30], VEC[i][29:22]);
            @(posedge clk); #1;
            check(int'(VEC[i][3:0]), outs(), VEC[i][21:4]);
            @(negedge clk);
            release_bus();
        end

        // R2: write then read back with no clock edge in between
        @(negedge clk);
        drive(2'd0, 16'h00A8, 8'h3C);
        #0.8 wr = 1'b0;
        #0.4 rd = 1'b1;
        #0.4 check(2, outs(), {8'h3C, 1'b1, 4'b0, 4'b0, 1'b0});
        release_bus();

        // R2 on the sub-slot register of slot 3 (0x3C: page3 maps slot0, not expanded)
        @(negedge clk);
        drive(2'd0, 16'h00A8, 8'hFF);
        #0.8 wr = 1'b0;
        #0.2 drive(2'd2, 16'hFFFF, 8'hA5);
        #0.6 wr = 1'b0;
        #0.2 rd = 1'b1;
        #0.4 check(2, outs(), {8'h5A, 1'b1, 4'b0, 4'b0, 1'b0});
        release_bus();

        // R9: reset clears the primary and sub-slot registers
        reset_dut();
        @(negedge clk); drive(2'd1, 16'h00A8, 8'h00);
        @(posedge clk); #1 check(9, outs(), {8'h00, 1'b1, 4'b0, 4'b0, 1'b0});
        @(negedge clk); release_bus();
        @(negedge clk); drive(2'd3, 16'hFFFF, 8'h00);
        @(posedge clk); #1 check(9, outs(), {8'h00, 1'b0, 4'b0001, 4'b0, 1'b0});
        @(negedge clk); release_bus();
        @(negedge clk); drive(2'd0, 16'h00A8, 8'hC0);
        @(negedge clk); release_bus();
        @(negedge clk); drive(2'd3, 16'hFFFF, 8'h00);
        @(posedge clk); #1 check(9, outs(), {8'hFF, 1'b1, 4'b0, 4'b0, 1'b0});
        @(negedge clk); release_bus();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule